// File: doc/BRIEF.md
# Block Copy and Search Sequencer

This block carries out the repeating block-transfer and block-search instructions of an 8-bit processor as a standalone sequencer. A one-cycle start loads a source pointer, a destination pointer, a 16-bit count, an accumulator value, a direction and an operation. The operation is either a copy, which moves bytes from source to destination, or a search, which compares source bytes against the accumulator. A repeat enable chooses between a single step and a run that continues until the block is finished.

The engine reaches memory through a single request/acknowledge port. After every step the pointer, count and flag outputs show the state so far. When the run finishes, a one-cycle done pulse marks that the outputs hold final values, ready to be written back into the processor's register file.

Top module: `blkmove_engine`

## Requirements
- R1: Out of reset, busy, done, mem_req and mem_we are 0, and cnt_out, flag_z and flag_cnz are 0.
- R2: A copy step (op_cmp=0) reads the byte at the source pointer and writes that byte to the destination pointer. It then moves both pointers by one and lowers the count by one.
- R3: With dir_dec=0 the pointers step up by one. With dir_dec=1 they step down by one. In both directions the count always goes down by one per step.
- R4: A search step (op_cmp=1) reads the source byte and issues no write. It moves only the source pointer and lowers the count by one. It sets flag_z to 1 when the byte equals acc_in and clears it to 0 otherwise.
- R5: With rpt=1, steps repeat until the count reaches zero. With rpt=0, exactly one step runs.
- R6: A repeating search ends after the step in which the byte equals the accumulator, even when the count is still nonzero.
- R7: A starting count of 0 acts as 65536. The first step leaves 0xFFFF and the run continues.
- R8: After each step, flag_cnz is 1 when the remaining count is nonzero and 0 when it is zero.
- R9: Each access holds mem_req, mem_we and mem_addr steady until mem_ack. The write of a copy step is issued only after that step's read has been acknowledged.
- R10: done is high for exactly one cycle per run, while busy is low, and it arrives together with the final output values.
- R11: A start pulse during a run is ignored, and the run completes with its original parameters.
- R12: A copy leaves flag_z unchanged.
- R13: Pointers wrap modulo 2^16: 0xFFFF steps up to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| op_cmp | input | 1 | 0 = copy, 1 = search |
| dir_dec | input | 1 | 0 = increment pointers, 1 = decrement |
| rpt | input | 1 | 1 = repeat until finished, 0 = single step |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial count (0 means 65536) |
| acc_in | input | 8 | Accumulator value for search |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Remaining count |
| flag_z | output | 1 | Search match flag |
| flag_cnz | output | 1 | Count-nonzero flag |

## Verification
The bench targets the corner cases of this block. It runs a search whose match falls on the final counted step, where an engine that tested only one end condition would stop at the wrong moment or report the wrong flags. It runs a search from a zero count that matches after 300 steps; an engine that took zero literally would stop after one step with the count at zero. It copies across the 0xFFFF boundary, and it starts a copy after a search has set the match flag, which catches a carry-out of the pointer into a wider counter and any clobbering of flag_z by the copy. Memory latency varies across runs, and a second start pulse arrives in the middle of a run, so a sequencer that ran ahead of acknowledge or reloaded itself while busy would leave wrong bytes or wrong pointers behind.

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_cmp,
  input  logic          dir_dec,
  input  logic          rpt,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [DW-1:0] acc_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [CW-1:0] cnt_out,
  output logic          flag_z,
  output logic          flag_cnz
);
  localparam logic [AW-1:0] STEP_UP = AW'(1);
  localparam logic [AW-1:0] STEP_DN = '1;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_UPD} st_t;
  st_t st;

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dat_q, acc_q;
  logic          cmp_q, dec_q, rpt_q, fz_q, fcnz_q, done_q;

  wire [AW-1:0] step   = dec_q ? STEP_DN : STEP_UP;
  wire [CW-1:0] cnt_nx = cnt_q - CW'(1);
  wire          hit    = (dat_q == acc_q);
  wire          more   = rpt_q && (cnt_nx != '0) && !(cmp_q && hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      dat_q  <= '0;
      acc_q  <= '0;
      cmp_q  <= 1'b0;
      dec_q  <= 1'b0;
      rpt_q  <= 1'b0;
      fz_q   <= 1'b0;
      fcnz_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          src_q <= src_in;
          dst_q <= dst_in;
          cnt_q <= cnt_in;
          acc_q <= acc_in;
          cmp_q <= op_cmp;
          dec_q <= dir_dec;
          rpt_q <= rpt;
          st    <= S_RD;
        end
        S_RD: if (mem_ack) begin
          dat_q <= mem_rdata;
          st    <= cmp_q ? S_UPD : S_WR;
        end
        S_WR: if (mem_ack) st <= S_UPD;
        S_UPD: begin
          src_q  <= src_q + step;
          if (!cmp_q) dst_q <= dst_q + step;
          cnt_q  <= cnt_nx;
          fcnz_q <= (cnt_nx != '0);
          if (cmp_q) fz_q <= hit;
          if (more) st <= S_RD;
          else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = mem_we ? dst_q : src_q;
  assign mem_wdata = dat_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign src_out   = src_q;
  assign dst_out   = dst_q;
  assign cnt_out   = cnt_q;
  assign flag_z    = fz_q;
  assign flag_cnz  = fcnz_q;
endmodule

// File: rtl/blkmove_engine_chk.sv
module blkmove_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [CW-1:0] cnt_out
);
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  p_read_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> $past(mem_req && !mem_we && mem_ack));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_cnt_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (cnt_out != $past(cnt_out)) |-> cnt_out == $past(cnt_out) - CW'(1));
endmodule

bind blkmove_engine blkmove_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack), .cnt_out(cnt_out)
);

// File: tb/tb_blkmove_engine.sv
module tb_blkmove_engine;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        cmp, dec, rpt;
    logic [15:0] src, dst, cnt, acc_at;
    logic [2:0]  lat;
    logic [16:0] steps;
    logic        z;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0010, 16'h0080, 16'd5,  16'h0000, 3'd0, 17'd1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 16'h0020, 16'h0090, 16'd4,  16'h0000, 3'd2, 17'd4, 1'b0},
    '{1'b0, 1'b1, 1'b1, 16'h0032, 16'h00A2, 16'd3,  16'h0000, 3'd1, 17'd3, 1'b0},
    '{1'b1, 1'b0, 1'b0, 16'h0040, 16'h0000, 16'd2,  16'h0050, 3'd0, 17'd1, 1'b0},
    '{1'b1, 1'b0, 1'b1, 16'h0040, 16'h0000, 16'd10, 16'h0042, 3'd3, 17'd3, 1'b1},
    '{1'b1, 1'b1, 1'b1, 16'h0060, 16'h0000, 16'd4,  16'h0010, 3'd1, 17'd4, 1'b0},
    '{1'b1, 1'b1, 1'b1, 16'h0070, 16'h0000, 16'd3,  16'h006E, 3'd0, 17'd3, 1'b1},
    '{1'b0, 1'b0, 1'b1, 16'hFFFE, 16'h00C0, 16'd3,  16'h0000, 3'd2, 17'd3, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op_cmp = 1'b0, dir_dec = 1'b0, rpt = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [7:0]  acc_in = '0;
  logic mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;
  logic busy, done, flag_z, flag_cnz;
  logic [15:0] src_out, dst_out, cnt_out;

  int tests = 0, fails = 0, done_cnt = 0;
  logic hung = 1'b0, init_req = 1'b0;
  logic [2:0] lat = '0, wcnt = '0;
  logic [7:0] mem [1024];

  always #(CLK_PERIOD/2) clk = ~clk;

  blkmove_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cmp(op_cmp), .dir_dec(dir_dec),
    .rpt(rpt), .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .acc_in(acc_in),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
    .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
    .flag_z(flag_z), .flag_cnz(flag_cnz)
  );

  function automatic logic [7:0] pat(input logic [9:0] a);
    if (a < 10'd256) return a[7:0] * 8'd3 + 8'd1;
    else if (a == 10'h22B) return 8'hA5;
    else return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (init_req) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(10'(i));
      mem_ack <= 1'b0;
      wcnt <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt == lat) begin
          mem_ack <= 1'b1;
          wcnt <= '0;
          mem_rdata <= mem[mem_addr[9:0]];
          if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        end else wcnt <= wcnt + 3'd1;
      end
    end
  end

  always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic init_memory();
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
  endtask

  task automatic launch(input logic c, input logic d, input logic r, input logic [15:0] s,
                        input logic [15:0] t, input logic [15:0] n, input logic [7:0] a);
    @(negedge clk);
    op_cmp = c; dir_dec = d; rpt = r; src_in = s; dst_in = t; cnt_in = n; acc_in = a;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done();
    int k = 0;
    while (!done && k < 20000) begin
      @(negedge clk);
      k++;
    end
    if (!done) begin
      hung = 1'b1;
      tests++;
      fails++;
      $display("FAIL R10 watchdog: actual no done expected done");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);
    chk("R1", "cnt", 32'(cnt_out), 0);
    chk("R1", "flags", {30'd0, flag_z, flag_cnz}, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV && !hung; v++) begin
      vec_t e = VECS[v];
      logic [15:0] n16, es, ed;
      int d0;
      n16 = e.steps[15:0];
      init_memory();
      lat = e.lat;
      d0 = done_cnt;
      launch(e.cmp, e.dec, e.rpt, e.src, e.dst, e.cnt, pat(e.acc_at[9:0]));
      wait_done();
      if (hung) break;
      // R2 R3 R13 pointers; R4 source only for search
      es = e.dec ? e.src - n16 : e.src + n16;
      ed = e.cmp ? e.dst : (e.dec ? e.dst - n16 : e.dst + n16);
      chk(e.cmp ? "R4" : "R2", $sformatf("v%0d src", v), 32'(src_out), 32'(es));
      chk("R3", $sformatf("v%0d dst", v), 32'(dst_out), 32'(ed));
      // R5 R6 count
      chk(e.cmp ? "R6" : "R5", $sformatf("v%0d cnt", v), 32'(cnt_out), 32'(e.cnt - n16));
      chk("R8", $sformatf("v%0d cnz", v), 32'(flag_cnz), 32'((e.cnt - n16) != 0));
      chk(e.cmp ? "R4" : "R12", $sformatf("v%0d z", v), 32'(flag_z), 32'(e.z));
      @(negedge clk);
      chk("R10", $sformatf("v%0d pulse", v), 32'(done_cnt - d0), 1);
      chk("R10", $sformatf("v%0d done low", v), 32'(done), 0);
      if (!e.cmp)
        for (int k = 0; k < int'(e.steps); k++) begin
          logic [15:0] s, t;
          s = e.dec ? e.src - 16'(k) : e.src + 16'(k);
          t = e.dec ? e.dst - 16'(k) : e.dst + 16'(k);
          chk("R2", $sformatf("v%0d byte%0d", v, k), 32'(mem[t[9:0]]), 32'(pat(s[9:0])));
        end
      else begin
        // R4 search writes nothing
        logic ok = 1'b1;
        for (int i = 0; i < 1024; i++) if (mem[i] !== pat(10'(i))) ok = 1'b0;
        chk("R4", $sformatf("v%0d no write", v), 32'(ok), 1);
      end
    end

    // R7 zero count acts as 65536: match at 0x22B after 300 steps from 0x100
    if (!hung) begin
      init_memory();
      lat = 3'd0;
      launch(1'b1, 1'b0, 1'b1, 16'h0100, 16'h0000, 16'h0000, 8'hA5);
      wait_done();
      if (!hung) begin
        chk("R7", "src", 32'(src_out), 32'h022C);
        chk("R7", "cnt", 32'(cnt_out), 32'hFED4);
        chk("R8", "cnz", 32'(flag_cnz), 1);
        chk("R6", "z", 32'(flag_z), 1);
      end
    end

    // R11 start during a run is ignored
    if (!hung) begin
      int d0;
      init_memory();
      lat = 3'd1;
      d0 = done_cnt;
      launch(1'b0, 1'b0, 1'b1, 16'h0020, 16'h0090, 16'd4, 8'h00);
      repeat (3) @(negedge clk);
      op_cmp = 1'b1; dir_dec = 1'b1; src_in = 16'h0055; cnt_in = 16'd1; start = 1'b1;
      @(negedge clk) start = 1'b0;
      wait_done();
      if (!hung) begin
        chk("R11", "src", 32'(src_out), 32'h0024);
        chk("R11", "dst", 32'(dst_out), 32'h0094);
        chk("R11", "cnt", 32'(cnt_out), 0);
        chk("R12", "z kept", 32'(flag_z), 1);
        repeat (4) @(negedge clk);
        chk("R11", "one run", 32'(done_cnt - d0), 1);
        chk("R11", "idle", 32'(busy), 0);
        chk("R11", "byte", 32'(mem[10'h093]), 32'(pat(10'h023)));
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule